// File: doc/BRIEF.md
# Packed Byte SIMD ALU

This block is a 32-bit arithmetic unit that views each operand as four unsigned byte lanes and applies one operation to all four lanes at once. It targets pixel kernels: sums and differences of samples, lane-wise unsigned minimum and maximum, the rounded mean used when two prediction blocks are blended, and the add of a signed residual to an unsigned pixel with the result held inside the pixel range.

Each lane is a separate copy of the same byte datapath, and nothing passes between lanes. A parameter selects whether the combined result is registered, which gives one clock of latency, or passed straight to the output.

There is no state machine. The opcode picks the lane function in one cycle, and the only storage is the optional output register.

Top module: `simd_byte_alu`

## Requirements
- R1: Lane k occupies bits 8k+7:8k in both operands and in the result, with lane 0 at bits 7:0 and lane 3 at bits 31:24. No carry, borrow or other value passes from one lane to another.
- R2: Opcode 3'd0 (add) gives (a + b) mod 256 in each lane.
- R3: Opcode 3'd1 (subtract) gives (a - b) mod 256 in each lane.
- R4: Opcode 3'd2 gives the smaller of the two lanes, with both lanes compared as unsigned values.
- R5: Opcode 3'd3 gives the larger of the two lanes, with both lanes compared as unsigned values.
- R6: Opcode 3'd4 gives (a + b + 1) >> 1 in each lane. The sum is formed at 9 bits, so it does not overflow, and a half rounds up.
- R7: Opcode 3'd5 treats the a lane as unsigned 0..255 and the b lane as signed two's complement -128..127, and adds them. A sum above 255 gives 255 and a sum below 0 gives 0.
- R8: Opcodes 3'd6 and 3'd7 give a result of zero in every lane.
- R9: With the default REG_OUT=1, the result for the inputs present at a rising clock edge appears on res_o after that edge. An active-low asynchronous reset clears res_o to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the result |
| op_i | input | 3 | Lane operation select |
| a_i | input | 32 | First operand, four byte lanes |
| b_i | input | 32 | Second operand, four byte lanes |
| res_o | output | 32 | Lane-wise result |

## Verification
Each operation is driven with operands chosen so that a wrong width or a wrong signedness gives a visibly different byte. For add and subtract, lanes that wrap sit next to lanes that do not, so any carry or borrow leaking across a lane boundary shows up in the neighbouring byte. The minimum and maximum vectors pair 0x80 with 0x7F and 0xFF with 0x01, which tells an unsigned compare from a signed one. The average vectors include 0xFF+0xFF and odd sums, which expose a dropped ninth bit or rounding in the wrong direction. The clamped-add vectors reach both bounds, land exactly on 0 and 255, and use a large unsigned a with a negative b, which tells a signed residual from an unsigned one. Directed tests then check the reset value, the one-cycle latency and the zero result of the reserved opcodes.

// File: rtl/simd_byte_pkg.sv
package simd_byte_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        SOP_ADD   = 3'd0,
        SOP_SUB   = 3'd1,
        SOP_MINU  = 3'd2,
        SOP_MAXU  = 3'd3,
        SOP_AVGR  = 3'd4,
        SOP_CLAMP = 3'd5,
        SOP_RSV6  = 3'd6,
        SOP_RSV7  = 3'd7
    } simd_op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_byte_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  simd_op_e          op_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic [LANE_W-1:0] y_o
);
    localparam int SUM_W = LANE_W + 1;
    localparam int CLP_W = LANE_W + 2;
    localparam logic [LANE_W-1:0] PIX_MAX = '1;

    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] avg_w;
    logic [CLP_W-1:0] clamp_w;
    logic [LANE_W-1:0] clamp_y;

    // widened sums keep the carry out of the lane (R1, R6)
    assign sum_w   = {1'b0, a_i} + {1'b0, b_i};
    assign avg_w   = sum_w + SUM_W'(1);
    // unsigned a plus sign-extended b, two guard bits (R7)
    assign clamp_w = {2'b00, a_i} + {{2{b_i[LANE_W-1]}}, b_i};

    always_comb begin
        if (clamp_w[CLP_W-1])
            clamp_y = '0;
        else if (clamp_w[CLP_W-2])
            clamp_y = PIX_MAX;
        else
            clamp_y = clamp_w[LANE_W-1:0];
    end

    always_comb begin
        unique case (op_i)
            SOP_ADD:   y_o = sum_w[LANE_W-1:0];
            SOP_SUB:   y_o = a_i - b_i;
            SOP_MINU:  y_o = (a_i < b_i) ? a_i : b_i;
            SOP_MAXU:  y_o = (a_i > b_i) ? a_i : b_i;
            SOP_AVGR:  y_o = avg_w[SUM_W-1:1];
            SOP_CLAMP: y_o = clamp_y;
            SOP_RSV6,
            SOP_RSV7:  y_o = '0;
            default:   y_o = '0;
        endcase
    end
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
    parameter int  W       = 32,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q_o <= '0;
                else
                    q_o <= d_i;
            end
        end else begin : g_comb
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/simd_byte_alu.sv
module simd_byte_alu
    import simd_byte_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int LANES   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OP_W-1:0]         op_i,
    input  logic [LANE_W*LANES-1:0] a_i,
    input  logic [LANE_W*LANES-1:0] b_i,
    output logic [LANE_W*LANES-1:0] res_o
);
    localparam int W  = LANE_W * LANES;
    localparam int HI = W - LANE_W;

    simd_op_e       op_e;
    logic [W-1:0]   lane_y;

    assign op_e = simd_op_e'(op_i);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            simd_lane #(.LANE_W(LANE_W)) u_lane (
                .op_i (op_e),
                .a_i  (a_i[k*LANE_W +: LANE_W]),
                .b_i  (b_i[k*LANE_W +: LANE_W]),
                .y_o  (lane_y[k*LANE_W +: LANE_W])
            );
        end
    endgenerate

    simd_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lane_y),
        .q_o   (res_o)
    );

    generate
        if (REG_OUT) begin : g_chk
            // top lane of add depends only on top input lanes (R1, R2)
            p_lane_iso_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_ADD) |=>
                res_o[W-1:HI] == LANE_W'($past(a_i[W-1:HI]) + $past(b_i[W-1:HI])));

            p_min_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_MINU) |=>
                (res_o[LANE_W-1:0] <= $past(a_i[LANE_W-1:0])) &&
                (res_o[LANE_W-1:0] <= $past(b_i[LANE_W-1:0])));

            p_max_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_MAXU) |=>
                (res_o[LANE_W-1:0] >= $past(a_i[LANE_W-1:0])) &&
                (res_o[LANE_W-1:0] >= $past(b_i[LANE_W-1:0])));

            p_avg_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_AVGR) && (a_i[LANE_W-1:0] <= b_i[LANE_W-1:0]) |=>
                (res_o[LANE_W-1:0] >= $past(a_i[LANE_W-1:0])) &&
                (res_o[LANE_W-1:0] <= $past(b_i[LANE_W-1:0])));

            p_clamp_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_CLAMP) && !b_i[LANE_W-1] |=>
                res_o[LANE_W-1:0] >= $past(a_i[LANE_W-1:0]));

            p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (op_e == SOP_RSV6 || op_e == SOP_RSV7) |=> res_o == '0);
        end
    endgenerate
endmodule

// File: tb/sim_simd_byte_alu.sv
module sim_simd_byte_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_byte_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o)
    );

    // {op, a, b, expected}
    localparam logic [98:0] VEC [NV] = '{
        {3'd0, 32'h01020304, 32'h10203040, 32'h11223344}, // R2 plain add
        {3'd0, 32'hFF80017F, 32'h01800001, 32'h00000180}, // R1 R2 wraps beside non-wraps
        {3'd0, 32'hFFFFFFFF, 32'h01010101, 32'h00000000}, // R1 all lanes wrap, no ripple
        {3'd1, 32'h00100503, 32'h01010A01, 32'hFF0FFB02}, // R3 borrows stay in lane
        {3'd2, 32'h80FF0010, 32'h7F01FF10, 32'h7F010010}, // R4 unsigned min
        {3'd3, 32'h80FF0010, 32'h7F01FF10, 32'h80FFFF10}, // R5 unsigned max
        {3'd4, 32'hFF000103, 32'hFF010204, 32'hFF010204}, // R6 9-bit sum, round up
        {3'd4, 32'h10000203, 32'h20000203, 32'h18000203}, // R6 even and equal lanes
        {3'd5, 32'hF0100580, 32'h20F0FA7F, 32'hFF0000FF}, // R7 high clamp, exact 0, low clamp, exact 255
        {3'd5, 32'h00FF7F01, 32'h80807F02, 32'h007FFE03}, // R7 signed b
        {3'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R8 reserved
        {3'd7, 32'h12345678, 32'h9ABCDEF0, 32'h00000000}  // R8 reserved
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD*3000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (2) @(negedge clk);
        chk("R9", res_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", res_o, 32'h0);

        // vector table, result one edge after drive
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_i = VEC[i][98:96];
            a_i  = VEC[i][95:64];
            b_i  = VEC[i][63:32];
            @(negedge clk);
            chk(req_of(VEC[i][98:96]), res_o, VEC[i][31:0]);
        end

        // R9 latency: new inputs not visible before the edge
        @(negedge clk);
        op_i = 3'd0; a_i = 32'h01010101; b_i = 32'h01010101;
        @(negedge clk);
        chk("R9", res_o, 32'h02020202);
        op_i = 3'd3; a_i = 32'h00000000; b_i = 32'hA0B0C0D0;
        #(CLK_PERIOD/4);
        chk("R9", res_o, 32'h02020202);
        @(negedge clk);
        chk("R9", res_o, 32'hA0B0C0D0);

        // R1 single lane change affects only its own byte
        op_i = 3'd1; a_i = 32'h00000000; b_i = 32'h00000100;
        @(negedge clk);
        chk("R1", res_o, 32'h0000FF00);

        // R9 asynchronous reset clears at once
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk("R9", res_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule